// File: doc/BRIEF.md
# Continuous-Clock Serial ADC Frame Sequencer

This block reads a serial analog-to-digital converter that has a chip-select input, a serial clock input and a data output. Once enabled, it drives a serial clock that never pauses, and it divides the clock stream into repeating frames of fixed length. For the first sixteen clock periods of each frame it holds chip-select low and shifts in the converter's data. For the rest of the frame it holds chip-select high while the clock keeps running. The converter therefore always sees an unbroken clock stream, and the line between conversions is shaped purely by counting clock periods.

The serial clock is the system clock divided by an even parameter. Data is sampled on the rising serial-clock edge. Chip-select only changes together with a falling serial-clock edge. The frame length is chosen by a static select input: 20 or 24 serial periods by default. Each frame is followed immediately by the next. A divider of 10 on a 100 MHz system clock gives roughly 416 thousand samples per second at the longer frame, which exceeds the 350 thousand target.

The twelve most significant of the sixteen captured bits are delivered left-justified in a sixteen-bit word. The word sits in a one-entry register with a valid/ready handshake, a one-cycle sample strobe, and an overrun flag for words that overwrote an untaken predecessor.

Top module: `sadc_seq`

## Requirements
- R1: After reset, adc_cs_n is 1, adc_sclk is 0, out_valid is 0 and overrun is 0. No frame starts and these values hold while enable is 0.
- R2: While running, adc_sclk has a period of CLK_DIV system cycles, with CLK_DIV/2 cycles high and CLK_DIV/2 cycles low. The clock continues without a gap across frame boundaries.
- R3: The first frame starts on the first clock edge at which enable is seen high while idle: adc_cs_n goes low there. In every frame, adc_cs_n stays low for exactly 16 serial periods.
- R4: When frame_long is 0 a frame is 20 serial periods long, and when it is 1 a frame is 24 periods long. In both cases adc_cs_n is high for the periods after the first 16. The next frame begins immediately after the last period of the previous one.
- R5: frame_long is sampled only when a frame starts. A change during a frame affects only the following frame.
- R6: adc_sdo is sampled on each rising adc_sclk edge while adc_cs_n is low, most significant bit first. out_data[15:4] holds the first 12 bits received and out_data[3:0] is 0.
- R7: The word is loaded on the same clock edge at which adc_cs_n rises. At that edge out_valid becomes 1 and smp_strobe is 1 for one cycle. out_valid stays 1 until a cycle with out_ready high, after which it is 0 unless a new word arrives in that same cycle.
- R8: When a new word is loaded while out_valid is 1 and out_ready is 0, overrun becomes 1 alongside the new word. A word that is taken clears overrun. If the old word is taken in the same cycle that the new one arrives, overrun stays 0.
- R9: If enable is 0 at the end of a frame, the block stops there with adc_cs_n at 1 and adc_sclk at 0, and no further strobes occur.
- R10: adc_cs_n rises only on a system clock edge at which adc_sclk falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Starts the frame sequence; checked at each frame end |
| frame_long | input | 1 | Frame length select: 0 = 20 periods, 1 = 24 periods |
| adc_sdo | input | 1 | Serial data from the converter |
| adc_sclk | output | 1 | Free-running serial clock to the converter |
| adc_cs_n | output | 1 | Active-low chip-select to the converter |
| out_data | output | 16 | Left-justified conversion result |
| out_valid | output | 1 | Output register holds an untaken word |
| out_ready | input | 1 | Consumer takes the word when out_valid is high |
| smp_strobe | output | 1 | One-cycle pulse when a new word is loaded |
| overrun | output | 1 | Current word overwrote an untaken one |

## Verification
The bench checks the serial-clock duty across the frame boundary. A design that reloads its divider at the boundary would stretch the low phase there, and the converter would see a gap. It changes frame_long in the middle of a frame and measures the high gap of that frame and of the next one. A design that latches the select immediately would end the current frame early or late. It withholds out_ready across two frames to force an overrun and then takes a single word, which catches a flag that is never cleared or that fires when the word is taken on the capture edge. It also drives patterns with the low nibble set, so a design that sampled on the wrong edge, reversed bit order, or copied the low bits into the result would miscompare.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

   typedef enum logic {
      FRM_SHORT = 1'b0,
      FRM_LONG  = 1'b1
   } frm_sel_e;

   function automatic int pick_len(frm_sel_e sel, int short_len, int long_len);
      return (sel == FRM_LONG) ? long_len : short_len;
   endfunction

endpackage

// File: rtl/sadc_sclk_gen.sv
module sadc_sclk_gen #(
   parameter int CLK_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic sclk,
   output logic rise_now,
   output logic fall_now
);
   localparam int HALF = CLK_DIV / 2;
   localparam int DW   = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;

   generate
      if (CLK_DIV < 2 || (CLK_DIV % 2) != 0) begin : g_bad_div
         $error("CLK_DIV must be an even value of at least 2");
      end
   endgenerate

   logic [DW-1:0] div_q;

   assign rise_now = run && (div_q == DW'(HALF - 1));
   assign fall_now = run && (div_q == DW'(CLK_DIV - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         div_q <= '0;
         sclk  <= 1'b0;
      end else if (!run) begin
         div_q <= '0;
         sclk  <= 1'b0;
      end else begin
         div_q <= fall_now ? '0 : div_q + 1'b1;
         if (rise_now)
            sclk <= 1'b1;
         else if (fall_now)
            sclk <= 1'b0;
      end
   end

   // R2: a rising edge is only ever issued from the low phase
   a_r2_rise_from_low: assert property (@(posedge clk) disable iff (!rst_n)
      rise_now |-> !sclk);

   // R2: a falling edge is only ever issued from the high phase
   a_r2_fall_from_high: assert property (@(posedge clk) disable iff (!rst_n)
      fall_now |-> sclk);

endmodule

// File: rtl/sadc_frame_seq.sv
module sadc_frame_seq
   import sadc_pkg::*;
#(
   parameter int DATA_BITS = 16,
   parameter int LEN_A     = 20,
   parameter int LEN_B     = 24
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic frame_long,
   input  logic rise_now,
   input  logic fall_now,
   output logic run,
   output logic cs_n,
   output logic sample_en,
   output logic capture
);
   localparam int CW = $clog2(LEN_B + 1);

   generate
      if (LEN_A <= DATA_BITS || LEN_B < LEN_A) begin : g_bad_len
         $error("frame lengths must exceed DATA_BITS and LEN_B must be at least LEN_A");
      end
   endgenerate

   logic [CW-1:0] bit_q;
   logic [CW-1:0] len_q;
   logic [CW-1:0] len_next;

   assign len_next  = CW'(pick_len(frm_sel_e'(frame_long), LEN_A, LEN_B));
   assign sample_en = rise_now && (bit_q < CW'(DATA_BITS));
   assign capture   = fall_now && (bit_q == CW'(DATA_BITS - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run   <= 1'b0;
         cs_n  <= 1'b1;
         bit_q <= '0;
         len_q <= CW'(LEN_A);
      end else if (!run) begin
         if (enable) begin
            run   <= 1'b1;
            cs_n  <= 1'b0;
            bit_q <= '0;
            len_q <= len_next;
         end
      end else if (fall_now) begin
         if (capture)
            cs_n <= 1'b1;
         if (bit_q == len_q - 1'b1) begin
            bit_q <= '0;
            if (enable) begin
               cs_n  <= 1'b0;
               len_q <= len_next;
            end else begin
               run <= 1'b0;
            end
         end else begin
            bit_q <= bit_q + 1'b1;
         end
      end
   end

   // R1: while idle, chip-select is deasserted
   a_r1_idle_cs_high: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> cs_n);

   // R4: the period counter stays within the latched frame length
   a_r4_bit_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (bit_q < len_q));

   // R5: the latched length only changes when a frame starts
   a_r5_len_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !(fall_now && bit_q == len_q - 1'b1)) |=> $stable(len_q));

endmodule

// File: rtl/sadc_word_out.sv
module sadc_word_out #(
   parameter int DATA_BITS = 16,
   parameter int RES_BITS  = 12
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sample_en,
   input  logic                 sdo,
   input  logic                 capture,
   input  logic                 ready,
   output logic [DATA_BITS-1:0] data,
   output logic                 valid,
   output logic                 strobe,
   output logic                 ovr
);
   generate
      if (RES_BITS < 1 || RES_BITS > DATA_BITS) begin : g_bad_res
         $error("RES_BITS must lie between 1 and DATA_BITS");
      end
   endgenerate

   logic [DATA_BITS-1:0] sh_q;
   logic [DATA_BITS-1:0] word_w;
   logic                 take;

   generate
      if (RES_BITS == DATA_BITS) begin : g_full
         assign word_w = sh_q;
      end else begin : g_just
         assign word_w = {sh_q[DATA_BITS-1 -: RES_BITS], {(DATA_BITS - RES_BITS){1'b0}}};
      end
   endgenerate

   assign take = valid && ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_q   <= '0;
         data   <= '0;
         valid  <= 1'b0;
         strobe <= 1'b0;
         ovr    <= 1'b0;
      end else begin
         if (sample_en)
            sh_q <= {sh_q[DATA_BITS-2:0], sdo};
         strobe <= capture;
         if (capture) begin
            data  <= word_w;
            valid <= 1'b1;
            ovr   <= valid && !ready;
         end else if (take) begin
            valid <= 1'b0;
            ovr   <= 1'b0;
         end
      end
   end

   // R7: a strobe always comes with a valid word
   a_r7_strobe_valid: assert property (@(posedge clk) disable iff (!rst_n)
      strobe |-> valid);

   // R7: an untaken word stays valid
   a_r7_hold_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !ready) |=> valid);

   // R8: overrun is only ever reported against a held word
   a_r8_ovr_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
      ovr |-> valid);

endmodule

// File: rtl/sadc_seq.sv
module sadc_seq #(
   parameter int CLK_DIV   = 4,
   parameter int DATA_BITS = 16,
   parameter int RES_BITS  = 12,
   parameter int LEN_A     = 20,
   parameter int LEN_B     = 24
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 enable,
   input  logic                 frame_long,
   input  logic                 adc_sdo,
   output logic                 adc_sclk,
   output logic                 adc_cs_n,
   output logic [DATA_BITS-1:0] out_data,
   output logic                 out_valid,
   input  logic                 out_ready,
   output logic                 smp_strobe,
   output logic                 overrun
);
   logic run;
   logic rise_now;
   logic fall_now;
   logic sample_en;
   logic capture;

   sadc_sclk_gen #(.CLK_DIV(CLK_DIV)) u_clk (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .sclk     (adc_sclk),
      .rise_now (rise_now),
      .fall_now (fall_now)
   );

   sadc_frame_seq #(.DATA_BITS(DATA_BITS), .LEN_A(LEN_A), .LEN_B(LEN_B)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .enable     (enable),
      .frame_long (frame_long),
      .rise_now   (rise_now),
      .fall_now   (fall_now),
      .run        (run),
      .cs_n       (adc_cs_n),
      .sample_en  (sample_en),
      .capture    (capture)
   );

   sadc_word_out #(.DATA_BITS(DATA_BITS), .RES_BITS(RES_BITS)) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .sample_en (sample_en),
      .sdo       (adc_sdo),
      .capture   (capture),
      .ready     (out_ready),
      .data      (out_data),
      .valid     (out_valid),
      .strobe    (smp_strobe),
      .ovr       (overrun)
   );

   // R10: chip-select rises only together with a falling serial clock
   a_r10_cs_rise_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(adc_cs_n) |-> $fell(adc_sclk));

   // R3: each new word coincides with the end of the low chip-select window
   a_r3_strobe_at_cs_rise: assert property (@(posedge clk) disable iff (!rst_n)
      smp_strobe |-> $rose(adc_cs_n));

endmodule

// File: tb/sadc_seq_test.sv
module sadc_seq_test;
   localparam int D    = 4;
   localparam int HALF = D / 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enable = 1'b0;
   logic        frame_long = 1'b0;
   logic        adc_sdo = 1'b0;
   logic        out_ready = 1'b1;
   logic        adc_sclk, adc_cs_n, out_valid, smp_strobe, overrun;
   logic [15:0] out_data;

   int n_vec = 0;
   int n_bad = 0;
   bit cmp_on = 1'b0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   sadc_seq #(.CLK_DIV(D)) uut (
      .clk(clk), .rst_n(rst_n), .enable(enable), .frame_long(frame_long),
      .adc_sdo(adc_sdo), .adc_sclk(adc_sclk), .adc_cs_n(adc_cs_n),
      .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
      .smp_strobe(smp_strobe), .overrun(overrun)
   );

   // reference model, advanced on every rising system clock edge
   bit          m_run, m_sclk, m_cs, m_valid, m_ovr, m_stb;
   int          m_tick, m_len;
   logic [15:0] m_bits, m_data;

   always @(posedge clk) begin
      int nt;
      bit take, neww;
      if (!rst_n) begin
         m_run = 0; m_tick = 0; m_len = 20; m_sclk = 0; m_cs = 1;
         m_bits = '0; m_valid = 0; m_data = '0; m_ovr = 0; m_stb = 0;
      end else begin
         take = m_valid && out_ready;
         neww = 0;
         m_stb = 0;
         if (!m_run) begin
            if (enable) begin
               m_run = 1; m_tick = 0; m_cs = 0; m_sclk = 0;
               m_len = frame_long ? 24 : 20;
            end
         end else begin
            nt = m_tick + 1;
            if (nt % D == HALF) begin
               m_sclk = 1;
               if (m_tick / D < 16) m_bits = {m_bits[14:0], adc_sdo};
            end
            if (nt % D == 0) begin
               m_sclk = 0;
               if (nt / D == 16) begin m_cs = 1; neww = 1; end
               if (nt / D == m_len) begin
                  nt = 0;
                  if (enable) begin
                     m_cs = 0;
                     m_len = frame_long ? 24 : 20;
                  end else m_run = 0;
               end
            end
            m_tick = nt;
         end
         if (neww) begin
            m_ovr = m_valid && !take;
            m_valid = 1;
            m_data = m_bits & 16'hFFF0;
            m_stb = 1;
         end else if (take) begin
            m_valid = 0; m_ovr = 0;
         end
      end
   end

   task automatic check(string req, string what, int act, int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (cmp_on) begin
         n_vec++;
         if (adc_sclk !== m_sclk)    begin n_bad++; $display("FAIL R2 sclk: actual %b expected %b at %0t", adc_sclk, m_sclk, $time); end
         if (adc_cs_n !== m_cs)      begin n_bad++; $display("FAIL R3 cs_n: actual %b expected %b at %0t", adc_cs_n, m_cs, $time); end
         if (out_valid !== m_valid)  begin n_bad++; $display("FAIL R7 valid: actual %b expected %b at %0t", out_valid, m_valid, $time); end
         if (smp_strobe !== m_stb)   begin n_bad++; $display("FAIL R7 strobe: actual %b expected %b at %0t", smp_strobe, m_stb, $time); end
         if (overrun !== m_ovr)      begin n_bad++; $display("FAIL R8 overrun: actual %b expected %b at %0t", overrun, m_ovr, $time); end
         if (m_valid && out_data !== m_data) begin n_bad++; $display("FAIL R6 data: actual %h expected %h at %0t", out_data, m_data, $time); end
      end
   end

   // converter model: drives the next bit after each serial falling edge
   logic [15:0] pats [6] = '{16'hA5C3, 16'hFFFF, 16'h0000, 16'h8001, 16'h7FFE, 16'h3C5A};
   logic [15:0] cur_pat, latched_pat;
   int  pat_i = 0, pos = 0;
   bit  was_low = 0, prev_sclk = 0, prev_cs = 1;

   always @(negedge clk) begin
      if (adc_cs_n) begin
         pos = 0;
         if (was_low) begin pat_i++; was_low = 0; end
      end else begin
         if (!prev_cs && prev_sclk && !adc_sclk) pos++;
         was_low = 1;
      end
      cur_pat = pats[pat_i % 6];
      if (!adc_cs_n) latched_pat = cur_pat;
      adc_sdo = (pos < 16) ? cur_pat[15 - pos] : 1'b0;
      prev_sclk = adc_sclk;
      prev_cs = adc_cs_n;
   end

   // direct waveform and data measurements
   int  lo_cnt = 0, hi_cnt = 0, sk_lo = 0, sk_hi = 0, fr_len = 0;
   bit  mon_cs = 1, mon_sk = 0, cs_seen = 0, sk_seen = 0;

   always @(negedge clk) begin
      if (cmp_on) begin
         if (smp_strobe)
            check("R6", "word vs driven pattern", out_data, {latched_pat[15:4], 4'h0});
         if (mon_cs && !adc_cs_n) begin
            if (cs_seen) check("R4", "cs high gap", hi_cnt, (fr_len - 16) * D);
            cs_seen = 1; fr_len = m_len; lo_cnt = 0;
         end else if (!mon_cs && adc_cs_n) begin
            check("R3", "cs low length", lo_cnt, 16 * D);
            hi_cnt = 0;
         end
         if (!mon_sk && adc_sclk) begin
            if (sk_seen) check("R2", "sclk low phase", sk_lo, HALF);
            sk_seen = 1; sk_hi = 0;
         end else if (mon_sk && !adc_sclk) begin
            check("R2", "sclk high phase", sk_hi, HALF);
            sk_lo = 0;
         end
         lo_cnt++; hi_cnt++; sk_lo++; sk_hi++;
         mon_cs = adc_cs_n; mon_sk = adc_sclk;
      end
   end

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         finish_run();
      end
   end

   initial begin
      int strobes;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      cmp_on = 1'b1;
      // R1: reset values
      check("R1", "cs_n after reset", adc_cs_n, 1);
      check("R1", "sclk after reset", adc_sclk, 0);
      check("R1", "valid after reset", out_valid, 0);
      check("R1", "overrun after reset", overrun, 0);
      repeat (20) @(negedge clk);
      check("R1", "cs_n with enable low", adc_cs_n, 1);
      check("R1", "sclk with enable low", adc_sclk, 0);

      // R3: start on first edge with enable high
      enable = 1'b1;
      @(negedge clk);
      check("R3", "cs_n low on first edge", adc_cs_n, 0);
      repeat (20 * D * 5) @(negedge clk);

      // R5: select changes mid-frame
      repeat (3 * D) @(negedge clk);
      frame_long = 1'b1;
      repeat (24 * D * 4) @(negedge clk);

      // R8: withhold ready across two words
      out_ready = 1'b0;
      repeat (24 * D * 2 + 8) @(negedge clk);
      check("R8", "overrun raised", overrun, 1);
      check("R7", "valid held", out_valid, 1);
      out_ready = 1'b1;
      @(negedge clk);
      out_ready = 1'b0;
      check("R7", "valid cleared after take", out_valid, 0);
      check("R8", "overrun cleared after take", overrun, 0);
      repeat (24 * D) @(negedge clk);
      out_ready = 1'b1;

      // R4: back to short frames, with and without a second select change
      frame_long = 1'b0;
      repeat (20 * D * 3 + 5) @(negedge clk);
      frame_long = 1'b1;
      repeat (24 * D * 2) @(negedge clk);

      // R9: stop at the end of the frame
      enable = 1'b0;
      repeat (24 * D + 4) @(negedge clk);
      check("R9", "cs_n after stop", adc_cs_n, 1);
      check("R9", "sclk after stop", adc_sclk, 0);
      strobes = 0;
      for (int k = 0; k < 40; k++) begin
         @(negedge clk);
         if (smp_strobe || adc_sclk || !adc_cs_n) strobes++;
      end
      check("R9", "activity while stopped", strobes, 0);
      done = 1'b1;
      finish_run();
   end

endmodule